// File: doc/BRIEF.md
# Eight-Level Thermal Threshold Interrupt Unit

This block watches a 9-bit temperature code coming from an on-die sensor and raises interrupts when the reading crosses programmed trip points. Software programs up to eight upward trip codes and eight downward trip codes through a small 32-bit register port. It enables the levels it cares about and then waits on a single interrupt line. When the line fires, software reads the pending register to see which crossings occurred. It acknowledges them by writing ones back to the same register.

A sample is accepted only while the core is switched on. Two options change where the code comes from. With power-down detection enabled, a sample flagged by the sensor as taken in power-down is discarded, so the last good reading is kept. With emulation enabled, a code written by software replaces the sensor on every cycle. That code drives both the current-temperature register and every threshold comparison, which lets firmware exercise its thermal policy with no real heat.

Top module: `thermo_alarm`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Status register (offset 0x000) bit 0 reads 0 until the first sample has been accepted, then reads 1 until reset.
- R3: A sample is accepted only while control register (0x004) bit 0 (core on) is 1. An accepted code appears in bits [8:0] of the current-temperature register (0x040) one clock after it is presented. While the core is off, samples leave that register unchanged.
- R4: Upward trip codes are held at 0x050..0x05C and downward trip codes at 0x060..0x06C. The register at base+4k holds level 7-2k in bits [24:16] and level 6-2k in bits [8:0]. All other bits read 0.
- R5: Pending bit n (0..7) of the pending register (0x118) is set when an accepted code is greater than or equal to upward trip n while the previous current temperature was below it.
- R6: Pending bit 16+n is set when an accepted code is below downward trip n while the previous current temperature was at or above it.
- R7: A pending bit can only be set while the matching bit of the enable register (0x110: upward levels in bits [7:0], downward levels in bits [23:16]) is 1. Clearing an enable bit leaves an already set pending bit in place.
- R8: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. A crossing in the same cycle wins over the clear.
- R9: `irq` is high exactly when some pending bit and its enable bit are both 1.
- R10: Writing the control register with bit 0 low zeroes the enable register. While the core is off, writes to the enable register store zero.
- R11: When control bit 23 is set, a sample presented with `sns_pwrdn` high is discarded and the current temperature holds. When bit 23 is clear, `sns_pwrdn` has no effect.
- R12: Emulation register (0x160): bit 0 enables emulation and bits [15:7] hold the emulated code. While emulation is enabled and the core is on, that code is accepted on every cycle, with or without a sensor sample, and sensor samples are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sns_valid | input | 1 | Sensor presents a new code this cycle |
| sns_code | input | CODE_W | Sensor temperature code |
| sns_pwrdn | input | 1 | Sensor reports it was powered down for this sample |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | AW | Register byte offset for read and write |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a crossing that happens while the sensor is untrusted or silent. That covers a downward trip taken only after an upward one, and a trip fired purely by the emulated code. The bench reaches these by walking the sensor code through a planned series of values, so that each step crosses exactly one known level. It then switches on emulation with a code above the top level and sends no sensor sample. This shows that the emulated code alone sets the pending bit and that later sensor samples are ignored.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  // Register byte offsets
  localparam int OFS_STATUS = 'h000;
  localparam int OFS_CTRL   = 'h004;
  localparam int OFS_CURT   = 'h040;
  localparam int OFS_RISE   = 'h050;
  localparam int OFS_FALL   = 'h060;
  localparam int OFS_INTEN  = 'h110;
  localparam int OFS_PEND   = 'h118;
  localparam int OFS_EMUL   = 'h160;

  // Field positions
  localparam int CTL_CORE_BIT = 0;
  localparam int CTL_PD_BIT   = 23;
  localparam int FALL_GRP     = 16;
  localparam int EMU_EN_BIT   = 0;
  localparam int EMU_CODE_LSB = 7;
  localparam int HI_LANE      = 16;

  // Register index holding a level: highest levels sit in the first register
  function automatic int slot_of(input int lvl, input int nlev);
    return (nlev - 1 - lvl) / 2;
  endfunction

  // Odd levels use the upper lane, even levels the lower lane
  function automatic int lane_of(input int lvl);
    return (lvl % 2 != 0) ? HI_LANE : 0;
  endfunction

  function automatic logic went_up(input logic [15:0] prev, input logic [15:0] nxt,
                                   input logic [15:0] thr);
    return (nxt >= thr) && (prev < thr);
  endfunction

  function automatic logic went_down(input logic [15:0] prev, input logic [15:0] nxt,
                                     input logic [15:0] thr);
    return (nxt < thr) && (prev >= thr);
  endfunction
endpackage

// File: rtl/thermo_src.sv
module thermo_src #(
  parameter int CODE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              core_en,
  input  logic              pd_en,
  input  logic              emu_en,
  input  logic [CODE_W-1:0] emu_code,
  input  logic              sns_valid,
  input  logic [CODE_W-1:0] sns_code,
  input  logic              sns_pwrdn,
  output logic              sample_ok,
  output logic [CODE_W-1:0] new_code,
  output logic [CODE_W-1:0] cur_code,
  output logic              ready
);
  logic frozen;

  assign new_code  = emu_en ? emu_code : sns_code;
  assign frozen    = pd_en & sns_pwrdn;
  assign sample_ok = core_en & (emu_en | (sns_valid & ~frozen));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_code <= '0;
      ready    <= 1'b0;
    end else if (sample_ok) begin
      cur_code <= new_code;
      ready    <= 1'b1;
    end
  end

  a_r3_core_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |=> $stable(cur_code));
  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  a_r11_pd_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && pd_en && sns_pwrdn && !emu_en) |=> $stable(cur_code));
  a_r12_emul_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (core_en && emu_en) |=> (cur_code == $past(emu_code)));
endmodule

// File: rtl/thermo_levels.sv
module thermo_levels
  import thermo_pkg::*;
#(
  parameter int CODE_W = 9,
  parameter int NLEV   = 8
) (
  input  logic                         sample_ok,
  input  logic [CODE_W-1:0]            prev_code,
  input  logic [CODE_W-1:0]            new_code,
  input  logic [NLEV-1:0][CODE_W-1:0]  rise_thr,
  input  logic [NLEV-1:0][CODE_W-1:0]  fall_thr,
  output logic [NLEV-1:0]              rise_hit,
  output logic [NLEV-1:0]              fall_hit
);
  for (genvar g = 0; g < NLEV; g++) begin : g_lvl
    assign rise_hit[g] = sample_ok &
      went_up(16'(prev_code), 16'(new_code), 16'(rise_thr[g]));
    assign fall_hit[g] = sample_ok &
      went_down(16'(prev_code), 16'(new_code), 16'(fall_thr[g]));
  end
endmodule

// File: rtl/thermo_regs.sv
module thermo_regs
  import thermo_pkg::*;
#(
  parameter int CODE_W = 9,
  parameter int NLEV   = 8,
  parameter int AW     = 12,
  parameter int DW     = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wen,
  input  logic [AW-1:0]                addr,
  input  logic [DW-1:0]                wdata,
  output logic [DW-1:0]                rdata,
  input  logic [NLEV-1:0]              rise_hit,
  input  logic [NLEV-1:0]              fall_hit,
  input  logic [CODE_W-1:0]            cur_code,
  input  logic                         ready,
  output logic                         core_en,
  output logic                         pd_en,
  output logic                         emu_en,
  output logic [CODE_W-1:0]            emu_code,
  output logic [NLEV-1:0][CODE_W-1:0]  rise_thr,
  output logic [NLEV-1:0][CODE_W-1:0]  fall_thr,
  output logic                         irq
);
  localparam int NREG = NLEV / 2;

  logic [NLEV-1:0] en_r, en_f, pend_r, pend_f;
  logic wr_ctl, wr_inten, wr_pend, wr_emul;
  logic [NLEV-1:0] clr_r, clr_f;
  logic unused_wdata;

  assign wr_ctl   = wen && (addr == AW'(OFS_CTRL));
  assign wr_inten = wen && (addr == AW'(OFS_INTEN));
  assign wr_pend  = wen && (addr == AW'(OFS_PEND));
  assign wr_emul  = wen && (addr == AW'(OFS_EMUL));
  assign clr_r    = wr_pend ? wdata[0 +: NLEV] : '0;
  assign clr_f    = wr_pend ? wdata[FALL_GRP +: NLEV] : '0;
  assign unused_wdata = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_en  <= 1'b0;
      pd_en    <= 1'b0;
      emu_en   <= 1'b0;
      emu_code <= '0;
      en_r     <= '0;
      en_f     <= '0;
      pend_r   <= '0;
      pend_f   <= '0;
    end else begin
      if (wr_ctl) begin
        core_en <= wdata[CTL_CORE_BIT];
        pd_en   <= wdata[CTL_PD_BIT];
      end
      if (wr_ctl && !wdata[CTL_CORE_BIT]) begin
        en_r <= '0;
        en_f <= '0;
      end else if (wr_inten) begin
        en_r <= core_en ? wdata[0 +: NLEV] : '0;
        en_f <= core_en ? wdata[FALL_GRP +: NLEV] : '0;
      end
      if (wr_emul) begin
        emu_en   <= wdata[EMU_EN_BIT];
        emu_code <= wdata[EMU_CODE_LSB +: CODE_W];
      end
      pend_r <= (pend_r & ~clr_r) | (rise_hit & en_r);
      pend_f <= (pend_f & ~clr_f) | (fall_hit & en_f);
    end
  end

  for (genvar g = 0; g < NLEV; g++) begin : g_thr
    localparam int SLOT = slot_of(g, NLEV);
    localparam int LANE = lane_of(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_thr[g] <= '0;
        fall_thr[g] <= '0;
      end else if (wen) begin
        if (addr == AW'(OFS_RISE + 4 * SLOT)) rise_thr[g] <= wdata[LANE +: CODE_W];
        if (addr == AW'(OFS_FALL + 4 * SLOT)) fall_thr[g] <= wdata[LANE +: CODE_W];
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(OFS_STATUS): rdata[0] = ready;
      AW'(OFS_CTRL): begin
        rdata[CTL_CORE_BIT] = core_en;
        rdata[CTL_PD_BIT]   = pd_en;
      end
      AW'(OFS_CURT): rdata[0 +: CODE_W] = cur_code;
      AW'(OFS_INTEN): begin
        rdata[0 +: NLEV]        = en_r;
        rdata[FALL_GRP +: NLEV] = en_f;
      end
      AW'(OFS_PEND): begin
        rdata[0 +: NLEV]        = pend_r;
        rdata[FALL_GRP +: NLEV] = pend_f;
      end
      AW'(OFS_EMUL): begin
        rdata[EMU_EN_BIT]             = emu_en;
        rdata[EMU_CODE_LSB +: CODE_W] = emu_code;
      end
      default: ;
    endcase
    for (int k = 0; k < NREG; k++) begin
      if (addr == AW'(OFS_RISE + 4 * k)) begin
        rdata[HI_LANE +: CODE_W] = rise_thr[NLEV - 1 - 2 * k];
        rdata[0 +: CODE_W]       = rise_thr[NLEV - 2 - 2 * k];
      end
      if (addr == AW'(OFS_FALL + 4 * k)) begin
        rdata[HI_LANE +: CODE_W] = fall_thr[NLEV - 1 - 2 * k];
        rdata[0 +: CODE_W]       = fall_thr[NLEV - 2 - 2 * k];
      end
    end
  end

  assign irq = (|(pend_r & en_r)) | (|(pend_f & en_f));

  a_r10_off_no_mask: assert property (@(posedge clk) disable iff (!rst_n)
    !core_en |-> (en_r == '0 && en_f == '0));
  a_r7_pend_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_r & ~$past(pend_r) & ~$past(en_r)) == '0) &&
    ((pend_f & ~$past(pend_f) & ~$past(en_f)) == '0));
  a_r8_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pend |=> ((pend_r & $past(wdata[0 +: NLEV]) & ~$past(rise_hit)) == '0));
  a_r9_irq_needs_core: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> core_en);
endmodule

// File: rtl/thermo_alarm.sv
module thermo_alarm #(
  parameter int CODE_W = 9,
  parameter int NLEV   = 8,
  parameter int AW     = 12,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sns_valid,
  input  logic [CODE_W-1:0] sns_code,
  input  logic              sns_pwrdn,
  input  logic              reg_wen,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  logic core_en, pd_en, emu_en, sample_ok, ready;
  logic [CODE_W-1:0] emu_code, new_code, cur_code;
  logic [NLEV-1:0][CODE_W-1:0] rise_thr, fall_thr;
  logic [NLEV-1:0] rise_hit, fall_hit;

  thermo_src #(.CODE_W(CODE_W)) u_src (
    .clk(clk), .rst_n(rst_n), .core_en(core_en), .pd_en(pd_en),
    .emu_en(emu_en), .emu_code(emu_code), .sns_valid(sns_valid),
    .sns_code(sns_code), .sns_pwrdn(sns_pwrdn), .sample_ok(sample_ok),
    .new_code(new_code), .cur_code(cur_code), .ready(ready)
  );

  thermo_levels #(.CODE_W(CODE_W), .NLEV(NLEV)) u_lvl (
    .sample_ok(sample_ok), .prev_code(cur_code), .new_code(new_code),
    .rise_thr(rise_thr), .fall_thr(fall_thr),
    .rise_hit(rise_hit), .fall_hit(fall_hit)
  );

  thermo_regs #(.CODE_W(CODE_W), .NLEV(NLEV), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .rise_hit(rise_hit),
    .fall_hit(fall_hit), .cur_code(cur_code), .ready(ready),
    .core_en(core_en), .pd_en(pd_en), .emu_en(emu_en), .emu_code(emu_code),
    .rise_thr(rise_thr), .fall_thr(fall_thr), .irq(irq)
  );
endmodule

// File: tb/sim_thermo_alarm.sv
`timescale 1ns/1ps
module sim_thermo_alarm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sns_valid = 1'b0;
  logic [8:0] sns_code = '0;
  logic sns_pwrdn = 1'b0;
  logic reg_wen = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  thermo_alarm u0 (
    .clk(clk), .rst_n(rst_n), .sns_valid(sns_valid), .sns_code(sns_code),
    .sns_pwrdn(sns_pwrdn), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam logic [11:0] A_STAT = 12'h000, A_CTRL = 12'h004, A_CURT = 12'h040,
    A_R76 = 12'h050, A_R54 = 12'h054, A_R32 = 12'h058, A_R10 = 12'h05C,
    A_F10 = 12'h06C, A_EN = 12'h110, A_PEND = 12'h118, A_EMU = 12'h160;

  function automatic logic [31:0] pair(input int hi, input int lo);
    return (32'(hi) << 16) | 32'(lo);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic chk_reg(input string tag, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic sample(input int code, input bit pd);
    sns_valid = 1'b1; sns_code = 9'(code); sns_pwrdn = pd;
    @(posedge clk); @(negedge clk);
    sns_valid = 1'b0; sns_pwrdn = 1'b0;
  endtask

  task automatic t_reset;
    chk_reg("R1 status", A_STAT, 0);
    chk_reg("R1 ctrl", A_CTRL, 0);
    chk_reg("R1 curt", A_CURT, 0);
    chk_reg("R1 pend", A_PEND, 0);
    check("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_core_gate;
    sample(50, 0);
    chk_reg("R3 core off no update", A_CURT, 0);
    chk_reg("R2 status before sample", A_STAT, 0);
    wr(A_CTRL, 32'h1);
    sample(50, 0);
    chk_reg("R3 curt after sample", A_CURT, 50);
    chk_reg("R2 status after sample", A_STAT, 1);
  endtask

  task automatic t_thresholds;
    wr(A_R54, 32'hFFFF_FFFF);
    chk_reg("R4 only 9-bit lanes kept", A_R54, 32'h01FF_01FF);
    wr(A_R76, pair(300, 250));
    wr(A_R54, pair(200, 150));
    wr(A_R32, pair(130, 110));
    wr(A_R10, pair(100, 80));
    wr(A_F10, pair(90, 70));
    chk_reg("R4 rising 1/0", A_R10, pair(100, 80));
    chk_reg("R4 rising 7/6", A_R76, pair(300, 250));
    chk_reg("R4 falling 1/0", A_F10, pair(90, 70));
  endtask

  task automatic t_crossings;
    wr(A_EN, 32'h0003_0001);
    chk_reg("R7 enable readback", A_EN, 32'h0003_0001);
    sample(85, 0);
    chk_reg("R5 rise level0", A_PEND, 32'h1);
    check("R9 irq on enabled pend", 32'(irq), 1);
    sample(120, 0);
    chk_reg("R7 disabled levels stay clear", A_PEND, 32'h1);
    wr(A_PEND, 32'h0);
    chk_reg("R8 zero write keeps", A_PEND, 32'h1);
    wr(A_PEND, 32'h1);
    chk_reg("R8 one write clears", A_PEND, 32'h0);
    check("R9 irq low after clear", 32'(irq), 0);
    sample(85, 0);
    chk_reg("R6 fall level1", A_PEND, 32'h0002_0000);
    sample(60, 0);
    chk_reg("R6 fall level0", A_PEND, 32'h0003_0000);
    wr(A_EN, 32'h0);
    check("R9 irq masked", 32'(irq), 0);
    chk_reg("R7 pend kept after disable", A_PEND, 32'h0003_0000);
    wr(A_PEND, 32'hFFFF_FFFF);
    chk_reg("R8 clear all", A_PEND, 32'h0);
  endtask

  task automatic t_core_off_mask;
    wr(A_EN, 32'h3);
    chk_reg("R10 enable while on", A_EN, 32'h3);
    wr(A_CTRL, 32'h0);
    chk_reg("R10 enable zeroed by core off", A_EN, 32'h0);
    wr(A_EN, 32'hFF);
    chk_reg("R10 enable write while off", A_EN, 32'h0);
  endtask

  task automatic t_powerdown;
    wr(A_CTRL, 32'h0080_0001);
    chk_reg("R11 ctrl readback", A_CTRL, 32'h0080_0001);
    sample(200, 1);
    chk_reg("R11 frozen on pwrdn", A_CURT, 60);
    sample(200, 0);
    chk_reg("R11 normal sample", A_CURT, 200);
    wr(A_CTRL, 32'h1);
    sample(180, 1);
    chk_reg("R11 pwrdn ignored when off", A_CURT, 180);
  endtask

  task automatic t_emulation;
    wr(A_EN, 32'h80);
    wr(A_EMU, (32'd310 << 7) | 32'h1);
    @(posedge clk); @(negedge clk);
    chk_reg("R12 emul readback", A_EMU, (32'd310 << 7) | 32'h1);
    chk_reg("R12 emul code in curt", A_CURT, 310);
    chk_reg("R12 emul fires rise level7", A_PEND, 32'h80);
    check("R12 irq from emul", 32'(irq), 1);
    sample(20, 0);
    chk_reg("R12 sensor ignored", A_CURT, 310);
    wr(A_EMU, 32'h0);
    sample(40, 0);
    chk_reg("R12 sensor back", A_CURT, 40);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_core_gate();
    t_thresholds();
    t_crossings();
    t_core_off_mask();
    t_powerdown();
    t_emulation();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule